// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block is the management-interface master of an Ethernet MAC. Software loads one 32-bit command word that holds the whole clause-22 management frame after its preamble. The fields are the start pattern, the opcode, the PHY and register addresses, the turnaround code and the 16-bit data. The controller sends 32 preamble ones and then shifts the word out MSB first on MDIO, using a management clock it divides down from the system clock. It changes MDIO only while MDC is low.

On a read, the controller releases MDIO for the turnaround and data bit times. It samples the PHY's data on each rising MDC edge and writes the 16 returned bits into the low half of the same command register, replacing whatever data field was written there. Software polls the idle flag and then reads the register back. The MDC divider takes one of four ratios: 8, 16, 32 or 64. Software picks the smallest ratio that keeps MDC at or below 2.5 MHz (64 above 80 MHz, 32 above 40 MHz, 16 above 20 MHz, 8 otherwise). A port-enable input gates all activity. MDIO is presented as separate out, output-enable and in signals for an external pad cell.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, idle is 1, mdc is 0, mdio_oe is 0 and mgmt_word is 0.
- R2: A cmd_wr pulse while port_en is 1 and idle is 1 loads cmd_wdata into mgmt_word and drops idle in the next cycle. idle stays 0 for exactly 64 MDC periods (64·N system cycles) and then returns to 1.
- R3: div_sel values 0, 1, 2 and 3 give an MDC period of N = 8, 16, 32 and 64 system cycles, with N/2 cycles low followed by N/2 cycles high. The setting is captured when a frame starts, and changing div_sel during the frame has no effect on it.
- R4: Every frame opens with 32 MDC periods in which MDIO is driven to 1 (mdio_oe = 1, mdio_o = 1).
- R5: After the preamble, mgmt_word bits 31 down to 0 are sent one per MDC period, MSB first. mdio_o and mdio_oe change only while MDC is low. For a write (bits 29:28 not equal to 2'b10), mdio_oe stays 1 for all 64 bit times.
- R6: For a read (bits 29:28 = 2'b10), mdio_oe is 0 for the last 18 bit times: two turnaround bits (word bits 17:16) and 16 data bits. All earlier bits are driven from the word.
- R7: During a read, mdio_i is sampled at each rising MDC edge of the data bit times, MSB first, into mgmt_word[15:0]. mgmt_word[31:16] keep the written value. mdio_i passes through a two-stage synchronizer before it is sampled.
- R8: A cmd_wr while a frame is in progress is ignored: mgmt_word[31:16] and the frame on the wire stay unchanged.
- R9: While port_en is 0, cmd_wr is ignored and mdc stays 0. Dropping port_en during a frame aborts it: in the next cycle idle is 1, mdc is 0 and mdio_oe is 0.
- R10: Whenever idle is 1, mdio_oe and mdc are both 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| port_en | input | 1 | Management port enable; 0 blocks and aborts frames |
| div_sel | input | 2 | MDC divider choice: 0→8, 1→16, 2→32, 3→64 |
| cmd_wr | input | 1 | Write strobe for the command register |
| cmd_wdata | input | 32 | Command word: [31:30] start, [29:28] opcode, [27:23] PHY, [22:18] register, [17:16] turnaround, [15:0] data |
| mgmt_word | output | 32 | Command register contents, with read data in [15:0] after a read |
| idle | output | 1 | 1 when no frame is running |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input from the pad |

## Verification
The assertions check, on every cycle, that MDIO and its enable never move while MDC is high. They also check that the line is released and MDC is low whenever the block is idle, that a launch is taken and a disabled port is quiet at once, and that the upper half of the register stays stable for the whole frame. Only the bench scenarios can show the serialized bit sequence, the turnaround release window, the exact frame length and MDC period for each divider ratio, and the assembly of PHY read data. They also show that a mid-frame divider change or command write leaves the frame untouched.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    localparam int unsigned CMD_W        = 32;
    localparam int unsigned DATA_W       = 16;
    localparam int unsigned TA_W         = 2;
    localparam int unsigned REG_AW       = 5;
    localparam int unsigned PHY_AW       = 5;
    localparam int unsigned OP_W         = 2;
    localparam int unsigned PREAMBLE_LEN = 32;
    localparam int unsigned DIV_SEL_W    = 2;
    localparam int unsigned MIN_DIV_LOG2 = 3;

    localparam int unsigned OP_LSB     = DATA_W + TA_W + REG_AW + PHY_AW;
    localparam int unsigned FRAME_BITS = PREAMBLE_LEN + CMD_W;
    localparam int unsigned IDX_W      = $clog2(FRAME_BITS);
    localparam int unsigned POS_W      = $clog2(CMD_W);
    localparam int unsigned DIV_CNT_W  = MIN_DIV_LOG2 + (1 << DIV_SEL_W) - 1;

    localparam logic [OP_W-1:0] OP_READ = 2'b10;

    // What the serializer does in one bit time.
    typedef struct packed {
        logic             in_word;   // past the preamble
        logic             drive;     // MDIO driven by this block
        logic             capture;   // sample the PHY into the word
        logic [POS_W-1:0] pos;       // word bit carried by this bit time
    } bit_plan_t;

    function automatic logic [DIV_CNT_W-1:0] div_last(input logic [DIV_SEL_W-1:0] sel);
        int unsigned full;
        full = 1 << (MIN_DIV_LOG2 + int'(sel));
        return DIV_CNT_W'(full - 1);
    endfunction

    function automatic logic [DIV_CNT_W-1:0] half_last(input logic [DIV_SEL_W-1:0] sel);
        int unsigned full;
        full = 1 << (MIN_DIV_LOG2 + int'(sel));
        return DIV_CNT_W'(full / 2 - 1);
    endfunction

    function automatic logic is_read_cmd(input logic [CMD_W-1:0] w);
        return w[OP_LSB +: OP_W] == OP_READ;
    endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen
    import mdio_mgmt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 run,
    input  logic                 start,
    input  logic [DIV_SEL_W-1:0] div_sel,
    output logic                 mdc,
    output logic                 rise_stb,
    output logic                 end_stb
);
    logic [DIV_SEL_W-1:0] sel_q;
    logic [DIV_CNT_W-1:0] cnt;

    // The ratio is frozen for the whole frame.
    always_ff @(posedge clk) begin
        if (rst)        sel_q <= '0;
        else if (start) sel_q <= div_sel;
    end

    assign rise_stb = run && (cnt == half_last(sel_q));
    assign end_stb  = run && (cnt == div_last(sel_q));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (end_stb) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else begin
            cnt <= cnt + 1'b1;
            if (rise_stb) mdc <= 1'b1;
        end
    end
endmodule

// File: rtl/mdio_bit_map.sv
module mdio_bit_map
    import mdio_mgmt_pkg::*;
(
    input  logic [IDX_W-1:0] bit_idx,
    input  logic             rd,
    output bit_plan_t        plan
);
    localparam logic [IDX_W-1:0] LAST_IDX     = IDX_W'(FRAME_BITS - 1);
    localparam logic [IDX_W-1:0] FIRST_WORD   = IDX_W'(PREAMBLE_LEN);
    localparam logic [POS_W-1:0] RELEASE_TOP  = POS_W'(DATA_W + TA_W - 1);
    localparam logic [POS_W-1:0] CAPTURE_TOP  = POS_W'(DATA_W - 1);

    logic [IDX_W-1:0] rel;
    logic             released;

    assign rel      = LAST_IDX - bit_idx;
    assign released = rd && plan.in_word && (plan.pos <= RELEASE_TOP);

    always_comb begin
        plan.in_word = bit_idx >= FIRST_WORD;
        plan.pos     = rel[POS_W-1:0];
        plan.drive   = !released;
        plan.capture = rd && plan.in_word && (plan.pos <= CAPTURE_TOP);
    end
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_mgmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             port_en,
    input  logic             cmd_wr,
    input  logic [CMD_W-1:0] cmd_wdata,
    input  logic             rise_stb,
    input  logic             end_stb,
    input  logic             mdio_s,
    output logic             busy,
    output logic             start,
    output logic [CMD_W-1:0] word,
    output logic             mdio_o,
    output logic             mdio_oe
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

    logic [IDX_W-1:0] bit_idx;
    logic             rd;
    bit_plan_t        plan;

    mdio_bit_map u_map (
        .bit_idx (bit_idx),
        .rd      (rd),
        .plan    (plan)
    );

    assign start = cmd_wr && port_en && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            rd      <= 1'b0;
            bit_idx <= '0;
            word    <= '0;
        end else if (!port_en) begin
            busy    <= 1'b0;
            bit_idx <= '0;
        end else if (start) begin
            busy    <= 1'b1;
            rd      <= is_read_cmd(cmd_wdata);
            bit_idx <= '0;
            word    <= cmd_wdata;
        end else if (busy) begin
            if (rise_stb && plan.capture) word[plan.pos] <= mdio_s;
            if (end_stb) begin
                if (bit_idx == LAST_IDX) busy <= 1'b0;
                else                     bit_idx <= bit_idx + 1'b1;
            end
        end
    end

    // Released bits show 1 so that read capture never moves mdio_o.
    always_comb begin
        mdio_oe = busy && plan.drive;
        if (!busy || !plan.in_word || !plan.drive) mdio_o = 1'b1;
        else                                       mdio_o = word[plan.pos];
    end
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
    import mdio_mgmt_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 port_en,
    input  logic [DIV_SEL_W-1:0] div_sel,
    input  logic                 cmd_wr,
    input  logic [CMD_W-1:0]     cmd_wdata,
    output logic [CMD_W-1:0]     mgmt_word,
    output logic                 idle,
    output logic                 mdc,
    output logic                 mdio_o,
    output logic                 mdio_oe,
    input  logic                 mdio_i
);
    logic busy, start, run, rise_stb, end_stb, mdio_s;
    logic sync_q [SYNC_STAGES];

    genvar gi;
    generate
        for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
            always_ff @(posedge clk) begin
                if (rst)          sync_q[gi] <= 1'b1;
                else if (gi == 0) sync_q[gi] <= mdio_i;
                else              sync_q[gi] <= sync_q[(gi == 0) ? 0 : gi - 1];
            end
        end
    endgenerate
    assign mdio_s = sync_q[SYNC_STAGES-1];

    assign run  = busy && port_en;
    assign idle = !busy;

    mdio_mdc_gen u_mdc (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .start    (start),
        .div_sel  (div_sel),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .end_stb  (end_stb)
    );

    mdio_frame_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .port_en   (port_en),
        .cmd_wr    (cmd_wr),
        .cmd_wdata (cmd_wdata),
        .rise_stb  (rise_stb),
        .end_stb   (end_stb),
        .mdio_s    (mdio_s),
        .busy      (busy),
        .start     (start),
        .word      (mgmt_word),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe)
    );
endmodule

// File: rtl/mdio_mgmt_ctrl_chk.sv
module mdio_mgmt_ctrl_chk (
    input logic        clk,
    input logic        rst,
    input logic        port_en,
    input logic        cmd_wr,
    input logic [31:0] cmd_wdata,
    input logic [31:0] mgmt_word,
    input logic        idle,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe
);
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        idle |-> (!mdio_oe && !mdc));

    a_r2_launch: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && port_en && idle) |=> (!idle && mgmt_word == $past(cmd_wdata)));

    a_r8_upper_hold: assert property (@(posedge clk) disable iff (rst)
        (!idle && !$past(idle)) |-> $stable(mgmt_word[31:16]));

    a_r5_data_moves_low: assert property (@(posedge clk) disable iff (rst)
        (!idle && !$stable(mdio_o)) |-> !mdc);

    a_r5_enable_moves_low: assert property (@(posedge clk) disable iff (rst)
        !$stable(mdio_oe) |-> !mdc);

    a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
        !port_en |=> (idle && !mdc && !mdio_oe));

    a_r3_high_min: assert property (@(posedge clk) disable iff (rst)
        $rose(mdc) |=> mdc);

    a_r3_low_min: assert property (@(posedge clk) disable iff (rst)
        $fell(mdc) |=> !mdc);
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_ctrl_chk u_chk (.*);

// File: tb/mdio_mgmt_ctrl_bench.sv
module mdio_mgmt_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        port_en = 1'b0;
    logic [1:0]  div_sel = 2'd0;
    logic        cmd_wr = 1'b0;
    logic [31:0] cmd_wdata = '0;
    logic [31:0] mgmt_word;
    logic        idle, mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    always #2.5 clk = ~clk;

    mdio_mgmt_ctrl u_mdio_mgmt_ctrl (.*);

    int checks = 0;
    int fails  = 0;
    int wd     = 0;

    // {div_sel, command word, PHY reply}
    localparam logic [49:0] VECS [0:5] = '{
        {2'd0, 32'h519201E1, 16'h0000},
        {2'd1, 32'h6F86BEEF, 16'h782D},
        {2'd2, 32'h5002A5C3, 16'h0000},
        {2'd3, 32'h687E0000, 16'h8001},
        {2'd0, 32'h610A1234, 16'hFFFF},
        {2'd0, 32'h610AFFFF, 16'h0000}
    };

    // PHY model and wire monitor
    logic [15:0] phy_data = '0;
    logic        bv [0:63];
    logic        bo [0:63];
    int rises = 0, falls = 0, cyc = 0, t_r0 = 0, t_r1 = 0, t_f0 = 0;
    logic mdc_prev = 1'b0;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (mdc && !mdc_prev) begin
            if (rises < 64) begin
                bv[rises] = mdio_o;
                bo[rises] = mdio_oe;
            end
            rises = rises + 1;
            if (rises == 1) t_r0 = cyc;
            if (rises == 2) t_r1 = cyc;
        end
        if (!mdc && mdc_prev) begin
            falls = falls + 1;
            if (falls == 1) t_f0 = cyc;
            if (rises >= 48 && rises < 64) mdio_i = phy_data[63 - rises];
            else                           mdio_i = 1'b1;
        end
        mdc_prev = mdc;
    end

    always @(posedge clk) begin
        wd = wd + 1;
        if (wd > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual %0d cycles expected below 150000", wd);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Launch one frame and wait for idle; optional mid-frame write and divider change.
    task automatic run_frame(input logic [1:0] sel, input logic [31:0] w,
                             input logic [15:0] reply, input int inj_at,
                             input logic [31:0] inj_w, input logic [1:0] sel_after,
                             output int dur);
        @(negedge clk);
        rises = 0; falls = 0; t_r0 = 0; t_r1 = 0; t_f0 = 0;
        phy_data = reply;
        div_sel = sel;
        cmd_wdata = w;
        cmd_wr = 1'b1;
        dur = 0;
        @(negedge clk);
        cmd_wr = 1'b0;
        div_sel = sel_after;
        chk(!idle, "R2", "idle after launch", {31'd0, idle}, 32'd0);
        chk(mgmt_word == w, "R2", "word after launch", mgmt_word, w);
        while (!idle && dur < 20000) begin
            dur = dur + 1;
            if (dur == inj_at) begin
                cmd_wdata = inj_w;
                cmd_wr = 1'b1;
            end else begin
                cmd_wr = 1'b0;
            end
            @(negedge clk);
        end
        cmd_wr = 1'b0;
    endtask

    task automatic check_wire(input int n, input logic [31:0] w, input int dur);
        bit rd;
        bit pre_ok, word_ok;
        rd = (w[29:28] == 2'b10);
        chk(dur == 64 * n, "R2", "busy cycles", dur, 64 * n);
        chk(rises == 64, "R4", "MDC rising edges", rises, 64);
        chk(t_r1 - t_r0 == n, "R3", "MDC period", t_r1 - t_r0, n);
        chk(t_f0 - t_r0 == n / 2, "R3", "MDC high width", t_f0 - t_r0, n / 2);
        pre_ok = 1'b1;
        for (int b = 0; b < 32; b++) if (!(bv[b] && bo[b])) pre_ok = 1'b0;
        chk(pre_ok, "R4", "preamble ones", {31'd0, pre_ok}, 32'd1);
        word_ok = 1'b1;
        for (int b = 32; b < 64; b++) begin
            int p;
            p = 63 - b;
            if (rd && p < 18) begin
                if (bo[b]) word_ok = 1'b0;
            end else if (!(bo[b] && bv[b] == w[p])) begin
                word_ok = 1'b0;
            end
        end
        chk(word_ok, rd ? "R6" : "R5", "serialized word and enable", {31'd0, word_ok}, 32'd1);
    endtask

    initial begin
        int dur;
        logic [31:0] w, exp;
        logic [15:0] reply;
        logic [1:0]  sel;
        int n;

        repeat (4) @(negedge clk);
        // R1 reset values
        chk(idle == 1'b1, "R1", "idle in reset", {31'd0, idle}, 32'd1);
        chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1", "mdc/oe in reset", {30'd0, mdc, mdio_oe}, 32'd0);
        chk(mgmt_word == 32'd0, "R1", "word in reset", mgmt_word, 32'd0);
        rst = 1'b0;
        port_en = 1'b1;
        @(negedge clk);

        for (int v = 0; v < 6; v++) begin
            sel = VECS[v][49:48];
            w = VECS[v][47:16];
            reply = VECS[v][15:0];
            n = 8 << sel;
            exp = (w[29:28] == 2'b10) ? {w[31:16], reply} : w;
            run_frame(sel, w, reply, -1, 32'd0, sel, dur);
            check_wire(n, w, dur);
            chk(mgmt_word == exp, "R7", "word after frame", mgmt_word, exp);
            chk(!mdio_oe && !mdc, "R10", "line quiet when idle", {30'd0, mdc, mdio_oe}, 32'd0);
        end

        // R8: write during a frame is ignored; R3: divider change mid-frame ignored
        run_frame(2'd0, 32'h5002A5C3, 16'h0, 20, 32'h6F86BEEF, 2'd3, dur);
        check_wire(8, 32'h5002A5C3, dur);
        chk(mgmt_word == 32'h5002A5C3, "R8", "word after ignored write", mgmt_word, 32'h5002A5C3);

        // R9: disabled port ignores a write
        @(negedge clk);
        port_en = 1'b0;
        cmd_wdata = 32'h6F86BEEF;
        cmd_wr = 1'b1;
        rises = 0;
        @(negedge clk);
        cmd_wr = 1'b0;
        chk(idle, "R9", "idle with port off", {31'd0, idle}, 32'd1);
        repeat (100) @(negedge clk);
        chk(rises == 0, "R9", "MDC edges with port off", rises, 0);
        chk(mgmt_word == 32'h5002A5C3, "R9", "word with port off", mgmt_word, 32'h5002A5C3);

        // R9: abort mid-frame
        port_en = 1'b1;
        cmd_wdata = 32'h519201E1;
        cmd_wr = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0;
        repeat (50) @(negedge clk);
        chk(!idle, "R9", "frame running before abort", {31'd0, idle}, 32'd0);
        port_en = 1'b0;
        @(negedge clk);
        chk(idle && !mdc && !mdio_oe, "R9", "abort state",
            {29'd0, idle, mdc, mdio_oe}, 32'd4);
        port_en = 1'b1;
        repeat (4) @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule